// File: doc/BRIEF.md
# Audio Sample Playback DMA Engine

This block plays PCM audio from a buffer in memory. Software writes a 24-bit buffer start and end address plus a format byte, then sets the run bit. The engine reads 16-bit words through a simple request/acknowledge read port and advances its position by two bytes per word. It stores the words in a small sample FIFO and sends out one stereo frame per sample period. A prescaler on the system clock sets that period. The format byte picks mono or stereo, 8-bit or 16-bit samples, and one of three rates or mute.

When the position reaches the end address, the engine either stops or jumps back to the start address with no gap, as the loop bit selects. New start and end values only take effect when a run begins or at a loop point. Software can therefore queue the next buffer while the current one plays. At each buffer end the engine can pulse an interrupt line, a timer-event line, or both.

Top module: `audio_dma_player`

## Requirements
- R1: After reset, every register reads 0x00, `mem_req`, `out_valid`, `irq` and `evt` are low.
- R2: Register 0 holds the run bit (bit 0) and the loop bit (bit 1), and both read back. Writing the run bit as 1 while stopped starts a run: the position loads the start address with bit 0 cleared, and the sample FIFO is emptied. Writing 0x00 stops the run, and `mem_req` is low from the next cycle on.
- R3: While running, the engine requests the 16-bit word at the current position whenever the FIFO has room for one more word. It keeps `mem_addr` stable until `mem_ack`, and adds 2 to the position for each acknowledged word.
- R4: When an acknowledged word makes position+2 reach or pass the end address, one of two things happens. If the loop bit is clear, the run bit clears itself and the position stays at that value. If the loop bit is set, the position reloads the start address and fetching continues without a gap.
- R5: Writes to the start and end registers do not disturb a buffer in progress. They apply at the next run start or loop point.
- R6: Registers 3/4/5 hold the start address and 6/7/8 the end address, each as high/middle/low byte. Registers 9/10/11 read the live position as high/middle/low byte. The full value is hi<<16 + mid<<8 + lo.
- R7: Register 1 is the format byte. Bit 7 set means mono and clear means stereo. Bit 6 set means 16-bit samples and clear means 8-bit. Bits 1:0 are the rate code. The other bits read 0.
- R8: 16-bit stereo takes two words per frame, left first. 16-bit mono takes one word, sent on both channels. 8-bit stereo takes one word: the high byte is left and the low byte is right. 8-bit mono takes the high byte, then the low byte, of each word, one per frame. 8-bit samples appear in bits 15:8 of an output, with zeros below.
- R9: Rate codes 1, 2 and 3 give a sample period of DIV_LOW, DIV_MID and DIV_HIGH clocks. One frame is sent per period while the FIFO holds enough data. Rate code 0 mutes the output: no frames are sent, and fetching stops once the FIFO is full.
- R10: Register 2 bit 0 routes the end-of-buffer event to `irq`, and bit 1 routes it to `evt`. Each is a one-cycle pulse in the cycle after the final word of a buffer is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 24 | Byte address of the requested word (even) |
| mem_ack | input | 1 | Read acknowledge, with data valid in the same cycle |
| mem_rdata | input | 16 | Read data word |
| out_valid | output | 1 | Frame strobe, one per sample period |
| out_left | output | 16 | Left sample |
| out_right | output | 16 | Right sample |
| irq | output | 1 | End-of-buffer interrupt pulse |
| evt | output | 1 | End-of-buffer timer-event pulse |

## Verification
Register reads are combinational, so the bench samples `reg_rdata` 1 ns after setting the index. A write shows at the next negative edge. A run starts on the clock edge that captures the control write, and the position advances on the edge that takes an acknowledge. `irq`/`evt` are high in the cycle after the final acknowledge, and the bench counts them on negative edges. A frame appears on `out_valid` one cycle after a prescaler tick. The scoreboard therefore does not depend on when the first frame comes: it compares frame order and content, and checks that later frames are exactly one sample period apart. Idle checks (mute, stop, end of buffer) wait several periods, so any stray frame is caught as unexpected.

// File: rtl/audio_dma_pkg.sv
package audio_dma_pkg;

    localparam int ADDR_W = 24;
    localparam int WORD_W = 16;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [3:0] {
        REG_CTRL    = 4'd0,
        REG_MODE    = 4'd1,
        REG_IRQEN   = 4'd2,
        REG_START_H = 4'd3,
        REG_START_M = 4'd4,
        REG_START_L = 4'd5,
        REG_END_H   = 4'd6,
        REG_END_M   = 4'd7,
        REG_END_L   = 4'd8,
        REG_POS_H   = 4'd9,
        REG_POS_M   = 4'd10,
        REG_POS_L   = 4'd11
    } reg_sel_e;

    typedef enum logic [1:0] {
        RATE_MUTE = 2'd0,
        RATE_LOW  = 2'd1,
        RATE_MID  = 2'd2,
        RATE_HIGH = 2'd3
    } rate_e;

    typedef struct packed {
        logic  mono;
        logic  wide;
        rate_e rate;
    } mode_t;

    typedef struct packed {
        word_t left;
        word_t right;
    } frame_t;

    function automatic logic [1:0] words_per_frame(mode_t m);
        return (m.wide && !m.mono) ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [7:0] mode_to_byte(mode_t m);
        return {m.mono, m.wide, 4'b0000, m.rate};
    endfunction

    function automatic mode_t byte_to_mode(logic [7:0] b);
        mode_t m;
        m.mono = b[7];
        m.wide = b[6];
        m.rate = rate_e'(b[1:0]);
        return m;
    endfunction

    // lane 2 = bits 23:16, lane 1 = bits 15:8, lane 0 = bits 7:0
    function automatic addr_t put_byte(addr_t v, logic [1:0] lane, logic [7:0] b);
        addr_t r;
        r = v;
        case (lane)
            2'd2:    r[23:16] = b;
            2'd1:    r[15:8]  = b;
            default: r[7:0]   = b;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] get_byte(addr_t v, logic [1:0] lane);
        case (lane)
            2'd2:    return v[23:16];
            2'd1:    return v[15:8];
            default: return v[7:0];
        endcase
    endfunction

    function automatic addr_t word_align(addr_t a);
        return {a[ADDR_W-1:1], 1'b0};
    endfunction

    function automatic word_t widen(logic [7:0] b);
        return {b, 8'h00};
    endfunction

endpackage

// File: rtl/audio_dma_regs.sv
module audio_dma_regs
    import audio_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [3:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       stop_req,
    input  addr_t      pos,
    output logic       play_en,
    output logic       loop_en,
    output logic       start_pulse,
    output mode_t      mode,
    output logic [1:0] irq_route,
    output addr_t      start_pend,
    output addr_t      end_pend
);

    reg_sel_e sel;
    logic     wr_ctrl;

    assign sel         = reg_sel_e'(reg_addr);
    assign wr_ctrl     = reg_wr && (sel == REG_CTRL);
    assign start_pulse = wr_ctrl && reg_wdata[0] && !play_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            play_en    <= 1'b0;
            loop_en    <= 1'b0;
            mode       <= '0;
            irq_route  <= '0;
            start_pend <= '0;
            end_pend   <= '0;
        end else begin
            if (wr_ctrl) begin
                play_en <= reg_wdata[0];
                loop_en <= reg_wdata[1];
            end else if (stop_req) begin
                play_en <= 1'b0;
            end
            if (reg_wr) begin
                case (sel)
                    REG_MODE:    mode       <= byte_to_mode(reg_wdata);
                    REG_IRQEN:   irq_route  <= reg_wdata[1:0];
                    REG_START_H: start_pend <= put_byte(start_pend, 2'd2, reg_wdata);
                    REG_START_M: start_pend <= put_byte(start_pend, 2'd1, reg_wdata);
                    REG_START_L: start_pend <= put_byte(start_pend, 2'd0, reg_wdata);
                    REG_END_H:   end_pend   <= put_byte(end_pend, 2'd2, reg_wdata);
                    REG_END_M:   end_pend   <= put_byte(end_pend, 2'd1, reg_wdata);
                    REG_END_L:   end_pend   <= put_byte(end_pend, 2'd0, reg_wdata);
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (sel)
            REG_CTRL:    reg_rdata = {6'b0, loop_en, play_en};
            REG_MODE:    reg_rdata = mode_to_byte(mode);
            REG_IRQEN:   reg_rdata = {6'b0, irq_route};
            REG_START_H: reg_rdata = get_byte(start_pend, 2'd2);
            REG_START_M: reg_rdata = get_byte(start_pend, 2'd1);
            REG_START_L: reg_rdata = get_byte(start_pend, 2'd0);
            REG_END_H:   reg_rdata = get_byte(end_pend, 2'd2);
            REG_END_M:   reg_rdata = get_byte(end_pend, 2'd1);
            REG_END_L:   reg_rdata = get_byte(end_pend, 2'd0);
            REG_POS_H:   reg_rdata = get_byte(pos, 2'd2);
            REG_POS_M:   reg_rdata = get_byte(pos, 2'd1);
            REG_POS_L:   reg_rdata = get_byte(pos, 2'd0);
            default:     reg_rdata = 8'h00;
        endcase
    end

    AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
        stop_req && !wr_ctrl |=> !play_en); // R4

    AST_STOP_WRITE_HALTS: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl && !reg_wdata[0] |=> !play_en); // R2

endmodule

// File: rtl/audio_dma_fetch.sv
module audio_dma_fetch
    import audio_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       play_en,
    input  logic       loop_en,
    input  logic       start_pulse,
    input  addr_t      start_pend,
    input  addr_t      end_pend,
    input  logic       fifo_room,
    input  logic [1:0] irq_route,
    input  logic       mem_ack,
    output logic       mem_req,
    output addr_t      mem_addr,
    output logic       push,
    output addr_t      pos,
    output logic       stop_req,
    output logic       irq,
    output logic       evt
);

    addr_t             cur;
    addr_t             end_act;
    logic [ADDR_W:0]   nxt_wide;
    logic              at_end;

    assign mem_req  = play_en && fifo_room;
    assign mem_addr = cur;
    assign pos      = cur;
    assign push     = mem_req && mem_ack;
    assign nxt_wide = {1'b0, cur} + (ADDR_W+1)'(2);
    assign at_end   = push && (nxt_wide >= {1'b0, end_act});
    assign stop_req = at_end && !loop_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '0;
            end_act <= '0;
            irq     <= 1'b0;
            evt     <= 1'b0;
        end else begin
            if (start_pulse) begin
                cur     <= word_align(start_pend);
                end_act <= end_pend;
            end else if (push) begin
                if (at_end && loop_en) begin
                    cur     <= word_align(start_pend);
                    end_act <= end_pend;
                end else begin
                    cur <= nxt_wide[ADDR_W-1:0];
                end
            end
            irq <= at_end && irq_route[0];
            evt <= at_end && irq_route[1];
        end
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack && !start_pulse |=> mem_addr == $past(mem_addr)); // R3

    AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> pos == {$past(start_pend[ADDR_W-1:1]), 1'b0}); // R2

    AST_IRQ_ROUTED: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(irq_route[0])); // R10

    AST_EVT_ROUTED: assert property (@(posedge clk) disable iff (rst)
        evt |-> $past(irq_route[1])); // R10

endmodule

// File: rtl/audio_dma_fifo.sv
module audio_dma_fifo
    import audio_dma_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       push,
    input  word_t                      wdata,
    input  logic [1:0]                 pop_n,
    output logic [$clog2(DEPTH):0]     count,
    output word_t                      head0,
    output word_t                      head1
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    word_t           store [DEPTH];
    logic [AW-1:0]   rptr;
    logic [AW-1:0]   wptr;

    assign head0 = store[rptr];
    assign head1 = store[rptr + AW'(1)];

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            store[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr + AW'(1);
            rptr  <= rptr + AW'(pop_n);
            count <= count + CW'(push) - CW'(pop_n);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push && !flush |-> (count < CW'(DEPTH)) || (pop_n != 2'd0)); // R3

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        !flush |-> CW'(pop_n) <= count); // R8

endmodule

// File: rtl/audio_dma_pacer.sv
module audio_dma_pacer
    import audio_dma_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int DIV_LOW  = 4000,
    parameter int DIV_MID  = 2000,
    parameter int DIV_HIGH = 1000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  mode_t                  mode,
    input  logic [$clog2(DEPTH):0] count,
    input  word_t                  head0,
    input  word_t                  head1,
    output logic [1:0]             pop_n,
    output logic                   out_valid,
    output word_t                  out_left,
    output word_t                  out_right
);

    localparam int CW    = $clog2(DEPTH) + 1;
    localparam int TIM_W = $clog2(DIV_LOW + 1);

    logic [TIM_W-1:0] tim;
    logic [TIM_W-1:0] reload;
    logic             tick;
    logic             ready;
    logic             emit;
    logic             half;
    logic             half_n;
    logic [7:0]       byte_sel;
    frame_t           frame_n;

    always_comb begin
        case (mode.rate)
            RATE_LOW:  reload = TIM_W'(DIV_LOW - 1);
            RATE_MID:  reload = TIM_W'(DIV_MID - 1);
            RATE_HIGH: reload = TIM_W'(DIV_HIGH - 1);
            default:   reload = '0;
        endcase
    end

    assign tick  = (mode.rate != RATE_MUTE) && (tim == '0);
    assign ready = count >= CW'(words_per_frame(mode));
    assign emit  = tick && ready;

    always_ff @(posedge clk) begin
        if (rst || mode.rate == RATE_MUTE) begin
            tim <= '0;
        end else if (tim == '0) begin
            tim <= reload;
        end else begin
            tim <= tim - TIM_W'(1);
        end
    end

    assign byte_sel = half ? head0[7:0] : head0[15:8];

    always_comb begin
        frame_n = '0;
        pop_n   = 2'd0;
        half_n  = half;
        if (emit) begin
            if (mode.wide && mode.mono) begin
                frame_n.left  = head0;
                frame_n.right = head0;
                pop_n         = 2'd1;
            end else if (mode.wide) begin
                frame_n.left  = head0;
                frame_n.right = head1;
                pop_n         = 2'd2;
            end else if (mode.mono) begin
                frame_n.left  = widen(byte_sel);
                frame_n.right = widen(byte_sel);
                pop_n         = half ? 2'd1 : 2'd0;
                half_n        = !half;
            end else begin
                frame_n.left  = widen(head0[15:8]);
                frame_n.right = widen(head0[7:0]);
                pop_n         = 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
            half      <= 1'b0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_left  <= frame_n.left;
                out_right <= frame_n.right;
            end
            half <= flush ? 1'b0 : half_n;
        end
    end

    AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (rst)
        mode.rate == RATE_MUTE |=> !out_valid); // R9

endmodule

// File: rtl/audio_dma_player.sv
module audio_dma_player
    import audio_dma_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_LOW    = 4000,
    parameter int DIV_MID    = 2000,
    parameter int DIV_HIGH   = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        mem_req,
    output logic [23:0] mem_addr,
    input  logic        mem_ack,
    input  logic [15:0] mem_rdata,
    output logic        out_valid,
    output logic [15:0] out_left,
    output logic [15:0] out_right,
    output logic        irq,
    output logic        evt
);

    localparam int CW = $clog2(FIFO_DEPTH) + 1;

    logic          play_en;
    logic          loop_en;
    logic          start_pulse;
    logic          stop_req;
    logic          push;
    logic          fifo_room;
    logic [1:0]    irq_route;
    logic [1:0]    pop_n;
    logic [CW-1:0] fifo_count;
    mode_t         mode;
    addr_t         start_pend;
    addr_t         end_pend;
    addr_t         pos;
    word_t         head0;
    word_t         head1;

    assign fifo_room = fifo_count < CW'(FIFO_DEPTH);

    audio_dma_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .stop_req   (stop_req),
        .pos        (pos),
        .play_en    (play_en),
        .loop_en    (loop_en),
        .start_pulse(start_pulse),
        .mode       (mode),
        .irq_route  (irq_route),
        .start_pend (start_pend),
        .end_pend   (end_pend)
    );

    audio_dma_fetch u_fetch (
        .clk        (clk),
        .rst        (rst),
        .play_en    (play_en),
        .loop_en    (loop_en),
        .start_pulse(start_pulse),
        .start_pend (start_pend),
        .end_pend   (end_pend),
        .fifo_room  (fifo_room),
        .irq_route  (irq_route),
        .mem_ack    (mem_ack),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .push       (push),
        .pos        (pos),
        .stop_req   (stop_req),
        .irq        (irq),
        .evt        (evt)
    );

    audio_dma_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (start_pulse),
        .push  (push),
        .wdata (mem_rdata),
        .pop_n (pop_n),
        .count (fifo_count),
        .head0 (head0),
        .head1 (head1)
    );

    audio_dma_pacer #(
        .DEPTH   (FIFO_DEPTH),
        .DIV_LOW (DIV_LOW),
        .DIV_MID (DIV_MID),
        .DIV_HIGH(DIV_HIGH)
    ) u_pacer (
        .clk      (clk),
        .rst      (rst),
        .flush    (start_pulse),
        .mode     (mode),
        .count    (fifo_count),
        .head0    (head0),
        .head1    (head1),
        .pop_n    (pop_n),
        .out_valid(out_valid),
        .out_left (out_left),
        .out_right(out_right)
    );

endmodule

// File: tb/audio_dma_player_test.sv
module audio_dma_player_test;

    localparam int D_LOW  = 24;
    localparam int D_MID  = 12;
    localparam int D_HIGH = 6;
    localparam int DEPTH  = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        out_valid;
    logic [15:0] out_left;
    logic [15:0] out_right;
    logic        irq;
    logic        evt;

    int total = 0;
    int bad = 0;
    int irq_cnt = 0;
    int evt_cnt = 0;
    int frames_seen = 0;
    int cyc = 0;
    int prev_cyc = 0;
    int exp_gap = 0;
    bit first = 1'b1;
    bit mem_hold = 1'b0;
    bit mem_slow = 1'b0;
    bit slow_tog = 1'b0;

    logic [15:0] wq [$];
    logic [31:0] sb [$];

    audio_dma_player #(
        .FIFO_DEPTH(DEPTH), .DIV_LOW(D_LOW), .DIV_MID(D_MID), .DIV_HIGH(D_HIGH)
    ) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .irq(irq), .evt(evt)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] mem_word(logic [23:0] a);
        return a[15:0] ^ 16'h3C5A;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: acknowledge decided on the falling edge
    always @(negedge clk) begin
        slow_tog = !slow_tog;
        if (mem_req && !mem_hold && (!mem_slow || slow_tog)) begin
            mem_ack   = 1'b1;
            mem_rdata = mem_word(mem_addr);
        end else begin
            mem_ack   = 1'b0;
        end
    end

    // monitor: pops the scoreboard as frames appear
    always @(negedge clk) begin
        if (!rst) begin
            if (irq) irq_cnt++;
            if (evt) evt_cnt++;
            if (out_valid) begin
                frames_seen++;
                if (sb.size() == 0) begin
                    chk(1'b0, "R8 unexpected frame", {out_left, out_right}, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = sb.pop_front();
                    chk({out_left, out_right} == e, "R8 frame", {out_left, out_right}, e);
                    if (!first)
                        chk((cyc - prev_cyc) == exp_gap, "R9 period",
                            32'(cyc - prev_cyc), 32'(exp_gap));
                end
                first    = 1'b0;
                prev_cyc = cyc;
            end
        end
    end

    task automatic wr_reg(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_pos(output logic [23:0] p);
        logic [7:0] h, m, l;
        rd_reg(4'd9, h);
        rd_reg(4'd10, m);
        rd_reg(4'd11, l);
        p = (24'(h) << 16) + (24'(m) << 8) + 24'(l);
    endtask

    task automatic set_buf(logic [23:0] s, logic [23:0] e);
        wr_reg(4'd3, s[23:16]); wr_reg(4'd4, s[15:8]); wr_reg(4'd5, s[7:0]);
        wr_reg(4'd6, e[23:16]); wr_reg(4'd7, e[15:8]); wr_reg(4'd8, e[7:0]);
    endtask

    task automatic gen_words(logic [23:0] s, logic [23:0] e);
        logic [24:0] a;
        a = {1'b0, s[23:1], 1'b0};
        do begin
            wq.push_back(mem_word(a[23:0]));
            a = a + 25'd2;
        end while (a < {1'b0, e});
    endtask

    task automatic build(bit mono, bit wide);
        while (wq.size() > 0) begin
            logic [15:0] w, w2;
            w = wq.pop_front();
            if (wide && mono) sb.push_back({w, w});
            else if (wide) begin
                w2 = wq.pop_front();
                sb.push_back({w, w2});
            end else if (mono) begin
                sb.push_back({w[15:8], 8'h00, w[15:8], 8'h00});
                sb.push_back({w[7:0], 8'h00, w[7:0], 8'h00});
            end else sb.push_back({w[15:8], 8'h00, w[7:0], 8'h00});
        end
    endtask

    task automatic drain(string tag);
        int n;
        n = 0;
        while (sb.size() != 0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(sb.size() == 0, tag, 32'(sb.size()), 32'h0);
        repeat (100) @(negedge clk);
    endtask

    task automatic wait_irq(int target);
        int n;
        n = 0;
        while (irq_cnt < target && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [23:0] p;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int i = 0; i < 12; i++) begin
            rd_reg(4'(i), d);
            chk(d == 8'h00, "R1 register after reset", 32'(d), 32'h0);
        end
        chk(!mem_req && !out_valid && !irq && !evt, "R1 outputs idle",
            {28'b0, mem_req, out_valid, irq, evt}, 32'h0);

        // R7: format byte keeps only its defined bits
        wr_reg(4'd1, 8'hFF);
        rd_reg(4'd1, d);
        chk(d == 8'hC3, "R7 format readback", 32'(d), 32'hC3);
        wr_reg(4'd1, 8'h00);

        // Test A: 16-bit mono, fast rate, odd start, irq line only
        wr_reg(4'd1, 8'hC3);
        wr_reg(4'd2, 8'h01);
        set_buf(24'h000101, 24'h000120);
        gen_words(24'h000101, 24'h000120);
        build(1'b1, 1'b1);
        exp_gap = D_HIGH; first = 1'b1;
        mem_hold = 1'b1;
        wr_reg(4'd0, 8'h01);
        rd_pos(p);
        chk(p == 24'h000100, "R2 position loads aligned start", 32'(p), 32'h100);
        rd_reg(4'd0, d);
        chk(d == 8'h01, "R2 run bit reads back", 32'(d), 32'h01);
        chk(mem_req && mem_addr == 24'h000100, "R3 request at start", {7'b0, mem_req, mem_addr}, 32'h01000100);
        mem_hold = 1'b0;
        drain("R8 16-bit mono frames");
        chk(irq_cnt == 1, "R10 irq pulse count", 32'(irq_cnt), 32'd1);
        chk(evt_cnt == 0, "R10 evt masked", 32'(evt_cnt), 32'd0);
        rd_reg(4'd0, d);
        chk(d == 8'h00, "R4 run bit self-clears", 32'(d), 32'h0);
        rd_pos(p);
        chk(p == 24'h000120, "R4 R6 final position", 32'(p), 32'h120);
        chk(!mem_req, "R4 no request after end", 32'(mem_req), 32'h0);

        // Test B: 8-bit stereo, mid rate, event route only
        irq_cnt = 0; evt_cnt = 0;
        wr_reg(4'd1, 8'h02);
        wr_reg(4'd2, 8'h02);
        set_buf(24'h001000, 24'h001010);
        gen_words(24'h001000, 24'h001010);
        build(1'b0, 1'b0);
        exp_gap = D_MID; first = 1'b1;
        wr_reg(4'd0, 8'h01);
        drain("R8 8-bit stereo frames");
        chk(evt_cnt == 1 && irq_cnt == 0, "R10 evt route", 32'(evt_cnt * 16 + irq_cnt), 32'h10);

        // Test C: 8-bit mono, low rate, slow memory
        mem_slow = 1'b1;
        wr_reg(4'd1, 8'h81);
        set_buf(24'h00ABC0, 24'h00ABC8);
        gen_words(24'h00ABC0, 24'h00ABC8);
        build(1'b1, 1'b0);
        exp_gap = D_LOW; first = 1'b1;
        wr_reg(4'd0, 8'h01);
        drain("R8 8-bit mono frames");
        mem_slow = 1'b0;

        // Test D: 16-bit stereo, fast rate
        wr_reg(4'd1, 8'h43);
        set_buf(24'h020000, 24'h020020);
        gen_words(24'h020000, 24'h020020);
        build(1'b0, 1'b1);
        exp_gap = D_HIGH; first = 1'b1;
        wr_reg(4'd0, 8'h01);
        drain("R8 16-bit stereo frames");

        // Test E: looping with a queued second buffer (R5, R4)
        irq_cnt = 0; evt_cnt = 0;
        wr_reg(4'd1, 8'hC2);
        wr_reg(4'd2, 8'h03);
        set_buf(24'h000200, 24'h000220);
        gen_words(24'h000200, 24'h000220);
        gen_words(24'h000400, 24'h000410);
        build(1'b1, 1'b1);
        exp_gap = D_MID; first = 1'b1;
        wr_reg(4'd0, 8'h03);
        set_buf(24'h000400, 24'h000410);
        wait_irq(1);
        wr_reg(4'd0, 8'h01);
        rd_reg(4'd0, d);
        chk(d[1] == 1'b0, "R2 loop bit readback", 32'(d), 32'h01);
        drain("R5 loop plays first buffer then queued one");
        chk(irq_cnt == 2 && evt_cnt == 2, "R10 both routes per buffer", 32'(irq_cnt * 16 + evt_cnt), 32'h22);
        rd_pos(p);
        chk(p == 24'h000410, "R4 loop then stop position", 32'(p), 32'h410);

        // Test F: mute holds output and fills FIFO
        wr_reg(4'd1, 8'hC0);
        set_buf(24'h000800, 24'h000840);
        wr_reg(4'd0, 8'h01);
        frames_seen = 0;
        repeat (100) @(negedge clk);
        chk(frames_seen == 0, "R9 mute sends nothing", 32'(frames_seen), 32'h0);
        rd_pos(p);
        chk(p == 24'h000810, "R9 fetch stops when FIFO full", 32'(p), 32'h810);
        chk(!mem_req, "R3 no request while full", 32'(mem_req), 32'h0);
        gen_words(24'h000800, 24'h000840);
        build(1'b1, 1'b1);
        exp_gap = D_HIGH; first = 1'b1;
        wr_reg(4'd1, 8'hC3);
        drain("R9 unmute resumes frames");

        // Test G: explicit stop, then a fresh run flushes stale words
        wr_reg(4'd1, 8'hC0);
        set_buf(24'h000900, 24'h000940);
        wr_reg(4'd0, 8'h01);
        repeat (50) @(negedge clk);
        wr_reg(4'd0, 8'h00);
        chk(!mem_req, "R2 stop drops request", 32'(mem_req), 32'h0);
        rd_reg(4'd0, d);
        chk(d == 8'h00, "R2 stop readback", 32'(d), 32'h0);
        repeat (20) @(negedge clk);
        rd_pos(p);
        chk(p == 24'h000910, "R2 position frozen after stop", 32'(p), 32'h910);
        set_buf(24'h000A00, 24'h000A08);
        gen_words(24'h000A00, 24'h000A08);
        build(1'b1, 1'b1);
        exp_gap = D_HIGH; first = 1'b1;
        wr_reg(4'd0, 8'h01);
        wr_reg(4'd1, 8'hC3);
        drain("R2 restart flushes stale samples");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule